// File: doc/BRIEF.md
# Programmable Biphasic Pulse Timer

This block sets the phase timing of one charge-balanced stimulus pulse. The pulse has up to three phases in a fixed order: an anodic phase, a gap, and a cathodic phase. An 18-bit setting word gives each phase one 6-bit field. A capture strobe copies the word into holding registers. An active-low start strobe then preloads three chained 6-bit up-counters from those registers and begins a pulse.

Each counter runs only while the counter before it in the chain has reached its terminal count of 63. A counter that reaches 63 stops. A phase therefore lasts 63 minus its setting, in clock cycles. A setting of 63 removes that phase. This lets one word select an anodic-only pulse, a cathodic-only pulse, or a biphasic pulse with or without a gap. After the last phase the chain stays locked until the next start strobe.

The block drives two enables, one per polarity. It runs from whatever clock the system provides. Both enables come straight from flip-flops.

Top module: `stim_phase_timer`

## Requirements
- R1: A synchronous active-high reset drives both enables low, clears the held settings to zero and leaves the chain locked. A start after reset with no capture gives 63 anodic, 63 gap and 63 cathodic cycles.
- R2: The setting word holds the anodic setting in bits [17:12], the gap setting in bits [11:6] and the cathodic setting in bits [5:0].
- R3: The held settings change only on a clock edge where the capture strobe is high. Changes to the setting word at other edges have no effect on later pulses.
- R4: When the start strobe is sampled low at an edge, the anodic enable is high from that edge on for exactly (63 − anodic setting) cycles.
- R5: The gap then lasts (63 − gap setting) cycles with both enables low. After it, the cathodic enable is high for (63 − cathodic setting) cycles.
- R6: A setting of 63 gives a zero-length phase. With anodic 63 the anodic enable never rises. With cathodic 63 the cathodic enable never rises. With gap 63 the cathodic phase follows the anodic phase with no idle cycle.
- R7: After the cathodic phase ends, both enables stay low until the next start strobe.
- R8: The anodic and cathodic enables are never high in the same cycle.
- R9: A start strobe during a pulse drops that pulse and restarts at the anodic phase.
- R10: When the capture strobe and the start strobe fall on the same edge, the new pulse uses the settings held before that edge. The newly captured word applies to the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, any frequency |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 18 | Phase settings: anodic [17:12], gap [11:6], cathodic [5:0] |
| cfg_stb | input | 1 | Capture strobe for cfg_word |
| start_n | input | 1 | Active-low start strobe; preloads the counters |
| anode_en | output | 1 | Anodic phase enable |
| cathode_en | output | 1 | Cathodic phase enable |

## Verification
A counter that loads, steps or freezes wrongly changes where an enable edge falls. The mismatch therefore appears at the ports on the first cycle after the faulty phase should have ended, or on the first cycle of the pulse when the wrong field is preloaded. A chain that fails to lock after the cathodic phase shows as an enable that rises again, within one pass of 64 cycles. The bench's reference model tracks the remaining length of each phase and compares both enables on every cycle. Because of that, a one-cycle error in any phase boundary is reported at that boundary.

// File: rtl/stim_phase_pkg.sv
package stim_phase_pkg;
  localparam int unsigned NUM_PHASES = 3;
  localparam int unsigned PH_ANODE = 0;
  localparam int unsigned PH_GAP   = 1;
  localparam int unsigned PH_CATH  = 2;
endpackage

// File: rtl/pulse_cfg_hold.sv
module pulse_cfg_hold #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)      held <= '0;
    else if (stb) held <= word_in;
  end

  // R3: capture happens on a strobe edge
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    stb |=> held == $past(word_in));
  // R3: without a strobe the held word is unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(held));
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             at_top
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load)      cnt_nxt = preset;
    else if (step) cnt_nxt = cnt_q + 1'b1;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= TOP;
    else     cnt_q <= cnt_nxt;
  end

  assign at_top = (cnt_q == TOP);

  // R7: a counter at terminal count never moves without a load
  a_r7_counter_frozen: assert property (@(posedge clk) disable iff (rst)
    at_top && !load |=> at_top);
endmodule

// File: rtl/stim_phase_timer.sv
module stim_phase_timer
  import stim_phase_pkg::*;
#(
  parameter int unsigned FIELD_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [3*FIELD_W-1:0]     cfg_word,
  input  logic                     cfg_stb,
  input  logic                     start_n,
  output logic                     anode_en,
  output logic                     cathode_en
);
  localparam int unsigned CFG_W = NUM_PHASES * FIELD_W;
  localparam logic [FIELD_W-1:0] TOP = '1;

  logic [CFG_W-1:0]      held;
  logic                  load;
  logic [NUM_PHASES-1:0] top;
  logic [NUM_PHASES-1:0] step;
  logic [FIELD_W-1:0]    preset  [NUM_PHASES];
  logic [FIELD_W-1:0]    cnt_nxt [NUM_PHASES];

  assign load = !start_n;

  pulse_cfg_hold #(.WORD_W(CFG_W)) u_hold (
    .clk(clk), .rst(rst), .stb(cfg_stb), .word_in(cfg_word), .held(held)
  );

  // Phase 0 (anodic) takes the top field, the last phase the bottom one.
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    assign preset[g] = held[(NUM_PHASES-1-g)*FIELD_W +: FIELD_W];
    phase_counter #(.CNT_W(FIELD_W)) u_cnt (
      .clk(clk), .rst(rst), .load(load), .preset(preset[g]),
      .step(step[g]), .cnt_nxt(cnt_nxt[g]), .at_top(top[g])
    );
  end

  // A counter steps only when every earlier counter has finished.
  always_comb begin
    logic prev_done;
    prev_done = 1'b1;
    for (int i = 0; i < NUM_PHASES; i++) begin
      step[i]   = prev_done && !top[i];
      prev_done = prev_done && top[i];
    end
  end

  logic anode_nxt, cathode_nxt;
  always_comb begin
    anode_nxt   = cnt_nxt[PH_ANODE] != TOP;
    cathode_nxt = (cnt_nxt[PH_ANODE] == TOP) && (cnt_nxt[PH_GAP] == TOP)
                  && (cnt_nxt[PH_CATH] != TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      anode_en   <= 1'b0;
      cathode_en <= 1'b0;
    end else begin
      anode_en   <= anode_nxt;
      cathode_en <= cathode_nxt;
    end
  end

  // R8: enables are mutually exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(anode_en && cathode_en));
  // R4: a start with a nonzero anodic length raises the anodic enable
  a_r4_start: assert property (@(posedge clk) disable iff (rst)
    !start_n && (held[CFG_W-1 -: FIELD_W] != TOP) |=> anode_en);
  // R6: anodic setting of 63 keeps the anodic enable low
  a_r6_skip_anode: assert property (@(posedge clk) disable iff (rst)
    !start_n && (held[CFG_W-1 -: FIELD_W] == TOP) |=> !anode_en);
  // R7: a finished chain keeps both enables low
  a_r7_locked: assert property (@(posedge clk) disable iff (rst)
    start_n && (&top) |=> !anode_en && !cathode_en);
endmodule

// File: tb/tb_stim_phase_timer.sv
module tb_stim_phase_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] cfg_word = '0;
  logic        cfg_stb = 1'b0;
  logic        start_n = 1'b1;
  logic        anode_en, cathode_en;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 1'b0;
  int cycles = 0;

  stim_phase_timer dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .cfg_stb(cfg_stb),
    .start_n(start_n), .anode_en(anode_en), .cathode_en(cathode_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: remaining cycles of each phase.
  int ha = 0, hd = 0, hc = 0;
  int rem_a = 0, rem_d = 0, rem_c = 0;
  always @(posedge clk) begin
    if (rst) begin
      ha = 0; hd = 0; hc = 0;
      rem_a = 0; rem_d = 0; rem_c = 0;
    end else begin
      if (!start_n) begin
        rem_a = 63 - ha; rem_d = 63 - hd; rem_c = 63 - hc;
      end else if (rem_a > 0) rem_a--;
      else if (rem_d > 0) rem_d--;
      else if (rem_c > 0) rem_c--;
      if (cfg_stb) begin
        ha = int'(cfg_word[17:12]);
        hd = int'(cfg_word[11:6]);
        hc = int'(cfg_word[5:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit ea, ec;
      cycles++;
      ea = rem_a > 0;
      ec = (rem_a == 0) && (rem_d == 0) && (rem_c > 0);
      checks++;
      if (anode_en !== ea || cathode_en !== ec) begin
        failures++;
        $display("FAIL %s t=%0t anode=%b exp=%b cathode=%b exp=%b",
                 cur_req, $time, anode_en, ea, cathode_en, ec);
      end
      if (cycles > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic capture(input int a, input int d, input int c);
    @(negedge clk);
    cfg_word = {a[5:0], d[5:0], c[5:0]};
    cfg_stb  = 1'b1;
    @(negedge clk);
    cfg_stb  = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk);
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
  endtask

  initial begin
    // R1: reset state, then a start with cleared settings
    cur_req = "R1";
    idle(3);
    checks++;
    if (anode_en !== 1'b0 || cathode_en !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset anode=%b cathode=%b exp=0 0", anode_en, cathode_en);
    end
    rst = 1'b0;
    fire();
    idle(200);

    // R2 and R5: 12 anodic, 4 gap, 8 cathodic
    cur_req = "R2_R5";
    capture(51, 59, 55);
    fire();
    idle(30);

    // R3: change the word without a strobe; the old settings stay
    cur_req = "R3";
    @(negedge clk);
    cfg_word = {6'd60, 6'd60, 6'd60};
    fire();
    idle(30);

    // R6: zero-length phases
    cur_req = "R6_cath_only";
    capture(63, 60, 58);
    fire();
    idle(12);
    cur_req = "R6_anode_only";
    capture(57, 60, 63);
    fire();
    idle(12);
    cur_req = "R6_no_gap";
    capture(59, 63, 60);
    fire();
    idle(12);
    cur_req = "R6_none";
    capture(63, 63, 63);
    fire();
    idle(5);

    // R7: long settle after a pulse; enables stay low
    cur_req = "R7";
    capture(61, 61, 61);
    fire();
    idle(80);

    // R9: restart while the pulse is running
    cur_req = "R9";
    capture(50, 55, 50);
    fire();
    idle(6);
    fire();
    idle(20);
    fire();
    idle(45);

    // R10: capture and start on the same edge
    cur_req = "R10";
    @(negedge clk);
    cfg_word = {6'd62, 6'd62, 6'd62};
    cfg_stb  = 1'b1;
    start_n  = 1'b0;
    @(negedge clk);
    cfg_stb  = 1'b0;
    start_n  = 1'b1;
    idle(45);
    fire();
    idle(6);

    // R8: mutual exclusion is checked every cycle above; one more mix
    cur_req = "R8";
    capture(62, 63, 62);
    fire();
    idle(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule